// File: doc/BRIEF.md
# VMEbus Daisy-Chain Interrupter

This block is a single-level interrupter for a VMEbus slave. A local interrupt request sets an internal pending flag, and the flag drives the active-low bus interrupt request line. A bus master answers with an interrupt acknowledge cycle. The block recognises that cycle when the address strobe and the acknowledge qualifier are both low. It then compares the three acknowledged-level address bits with a level set on a configuration input.

The block answers the acknowledge only when three things hold: the daisy-chain input is active, the level matches and its own request is pending. It answers by enabling an external vector latch onto the data bus. After a fixed number of clocks it asserts the data acknowledge. It answers in the same way for any data-strobe combination, so the size of the requested STATUS/ID does not matter. In every other acknowledge it passes the daisy chain to the next board. The vector contents and the bus transceivers sit outside the block.

All bus inputs pass through a two-stage synchronizer before any decision uses them. All outputs come straight from flip-flops.

Top module: `vme_irq_daisy`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `irq_n`, `iackout_n`, `vec_en_n` and `dtack_n` are all high.
- R2: A high on `local_req` at a clock edge, while no acknowledge is being handled, drives `irq_n` low on that edge. `irq_n` then stays low until the block has answered its own acknowledge.
- R3: A bus cycle with `as_n` low but `iack_n` high is not an acknowledge. No output changes in response to it.
- R4: Three conditions must hold together: `as_n`, `iack_n` and `iackin_n` are low, `addr_lvl` (positive logic, A3 in bit 2) equals `level_cfg`, and a request is pending. When at least one data strobe is also low, `vec_en_n` goes low on the third clock edge after the inputs change.
- R5: `dtack_n` goes low `DTACK_DLY` clocks after `vec_en_n` went low, provided `as_n` stays low throughout.
- R6: `irq_n` returns high one clock after `dtack_n` falls.
- R7: If an acknowledge reaches the block with `iackin_n` low while a request is pending but at a different level, `iackout_n` goes low. `vec_en_n` and `dtack_n` stay high.
- R8: If an acknowledge reaches the block with `iackin_n` low while nothing is pending, `iackout_n` goes low, even if the level matches. No vector and no acknowledge follow.
- R9: `iackout_n` returns high on the third clock edge after `iackin_n` goes high.
- R10: A strobe on `ds0_n` only, on `ds1_n` only, or on both produces the same response.
- R11: `dtack_n` and `vec_en_n` return high on the third clock edge after `as_n`, `ds0_n` and `ds1_n` are all high.
- R12: While `iackin_n` is high, an acknowledge cycle causes neither a response nor a pass. All outputs other than `irq_n` stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| local_req | input | 1 | Local interrupt request, active high |
| level_cfg | input | LVL_W | Programmed interrupt level |
| as_n | input | 1 | Bus address strobe, active low |
| ds0_n | input | 1 | Bus data strobe 0, active low |
| ds1_n | input | 1 | Bus data strobe 1, active low |
| iack_n | input | 1 | Bus acknowledge qualifier, active low |
| iackin_n | input | 1 | Daisy-chain acknowledge in, active low |
| addr_lvl | input | LVL_W | Acknowledged level from address lines A3..A1 |
| irq_n | output | 1 | Bus interrupt request, active low |
| iackout_n | output | 1 | Daisy-chain acknowledge out, active low |
| vec_en_n | output | 1 | Vector latch enable onto the data bus, active low |
| dtack_n | output | 1 | Bus data acknowledge, active low |

## Verification
The bench runs an acknowledge at the block's own level with `ds0_n` only, then with `ds1_n` only, then with both strobes. These three runs must give the same response, which separates the strobe-size handling from the level match. A mismatched level with a pending request, a matching level with nothing pending, and a matching level with the chain input still inactive each test a different arm of the pass/answer decision. A plain non-acknowledge bus cycle shows that the qualifier is required. Exact latencies are checked for the vector enable, the acknowledge, the release of the request and the release of the chain.

// File: rtl/vid_pkg.sv
package vid_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PASS = 2'd1,
    ST_RESP = 2'd2,
    ST_HOLD = 2'd3
  } ack_st_t;
endpackage

// File: rtl/vid_sync.sv
module vid_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/vid_pend.sv
module vid_pend (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic arm,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst)            pend <= 1'b0;
    else if (clr)       pend <= 1'b0;
    else if (arm & req) pend <= 1'b1;
  end
endmodule

// File: rtl/vid_ack_fsm.sv
module vid_ack_fsm
  import vid_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int DTACK_DLY = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             as_act,
  input  logic             ds_act,
  input  logic             iack_act,
  input  logic             iackin_act,
  input  logic [LVL_W-1:0] lvl_bus,
  input  logic [LVL_W-1:0] lvl_cfg,
  input  logic             pend,
  output logic             arm,
  output logic             clr,
  output logic             iackout_n,
  output logic             vec_en_n,
  output logic             dtack_n
);
  localparam int CW = (DTACK_DLY < 2) ? 1 : $clog2(DTACK_DLY);
  localparam logic [CW-1:0] CNT_LAST = CW'(DTACK_DLY - 1);

  ack_st_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic ack_cyc, hit;

  assign ack_cyc = as_act & iack_act & iackin_act;
  assign hit     = pend & (lvl_bus == lvl_cfg);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (ack_cyc) begin
          if (!hit) begin
            st_d = ST_PASS;
          end else if (ds_act) begin
            st_d  = ST_RESP;
            cnt_d = '0;
          end
        end
      end
      ST_PASS: if (!iackin_act) st_d = ST_IDLE;
      ST_RESP: begin
        if (!as_act)               st_d = ST_IDLE;
        else if (cnt_q == CNT_LAST) st_d = ST_HOLD;
        else                        cnt_d = cnt_q + 1'b1;
      end
      ST_HOLD: if (!as_act && !ds_act) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      iackout_n <= 1'b1;
      vec_en_n  <= 1'b1;
      dtack_n   <= 1'b1;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      iackout_n <= (st_d != ST_PASS);
      vec_en_n  <= !((st_d == ST_RESP) || (st_d == ST_HOLD));
      dtack_n   <= (st_d != ST_HOLD);
    end
  end

  assign arm = (st_q == ST_IDLE);
  assign clr = (st_q == ST_HOLD);

  // R5
  dtack_after_vec_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dtack_n) |-> !$past(vec_en_n));

  // R9
  chain_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(iackin_act) && !iackout_n) |=> iackout_n);

  // R3
  no_iack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!iack_act && arm) |=> (iackout_n && vec_en_n && dtack_n));
endmodule

// File: rtl/vme_irq_daisy.sv
module vme_irq_daisy #(
  parameter int LVL_W = 3,
  parameter int DTACK_DLY = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             local_req,
  input  logic [LVL_W-1:0] level_cfg,
  input  logic             as_n,
  input  logic             ds0_n,
  input  logic             ds1_n,
  input  logic             iack_n,
  input  logic             iackin_n,
  input  logic [LVL_W-1:0] addr_lvl,
  output logic             irq_n,
  output logic             iackout_n,
  output logic             vec_en_n,
  output logic             dtack_n
);
  localparam int SW = LVL_W + 5;

  logic [SW-1:0] raw, syn;
  logic pend, arm, clr;

  assign raw = {addr_lvl, iackin_n, iack_n, ds1_n, ds0_n, as_n};

  vid_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL({SW{1'b1}})) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  vid_pend u_pend (
    .clk(clk), .rst(rst), .req(local_req), .arm(arm), .clr(clr), .pend(pend)
  );

  vid_ack_fsm #(.LVL_W(LVL_W), .DTACK_DLY(DTACK_DLY)) u_fsm (
    .clk(clk), .rst(rst),
    .as_act(!syn[0]),
    .ds_act(!syn[1] || !syn[2]),
    .iack_act(!syn[3]),
    .iackin_act(!syn[4]),
    .lvl_bus(syn[SW-1:5]),
    .lvl_cfg(level_cfg),
    .pend(pend),
    .arm(arm), .clr(clr),
    .iackout_n(iackout_n), .vec_en_n(vec_en_n), .dtack_n(dtack_n)
  );

  assign irq_n = !pend;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (irq_n && iackout_n && vec_en_n && dtack_n));

  // R6
  irq_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dtack_n) |=> ##1 irq_n);

  // R4
  vec_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(vec_en_n) |-> !irq_n);

  // R7
  pass_or_answer_chk: assert property (@(posedge clk) disable iff (rst)
    !(!vec_en_n && !iackout_n));
endmodule

// File: tb/vme_irq_daisy_bench.sv
module vme_irq_daisy_bench;
  localparam int LVL_W = 3;
  localparam int DLY = 3;
  localparam logic [2:0] MY_LVL = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic local_req = 1'b0;
  logic as_n = 1'b1, ds0_n = 1'b1, ds1_n = 1'b1, iack_n = 1'b1, iackin_n = 1'b1;
  logic [2:0] addr_lvl = 3'd0;
  logic irq_n, iackout_n, vec_en_n, dtack_n;

  int tests = 0;
  int fails = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  vme_irq_daisy #(.LVL_W(LVL_W), .DTACK_DLY(DLY), .SYNC_STAGES(2)) u_vme_irq_daisy (
    .clk(clk), .rst(rst), .local_req(local_req), .level_cfg(MY_LVL),
    .as_n(as_n), .ds0_n(ds0_n), .ds1_n(ds1_n), .iack_n(iack_n),
    .iackin_n(iackin_n), .addr_lvl(addr_lvl),
    .irq_n(irq_n), .iackout_n(iackout_n), .vec_en_n(vec_en_n), .dtack_n(dtack_n)
  );

  // behavioural reference: 0 idle, 1 passing, 2 vector out, 3 acknowledged
  int m_st = 0, m_cnt = 0;
  bit m_pend = 0;
  logic [7:0] m_d1 = '1, m_d2 = '1;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_pend = 0; m_d1 = '1; m_d2 = '1;
    end else begin
      bit a_as, a_ds, a_iack, a_in;
      int nst;
      a_as = !m_d2[0]; a_ds = !m_d2[1] || !m_d2[2];
      a_iack = !m_d2[3]; a_in = !m_d2[4];
      nst = m_st;
      if (m_st == 0) begin
        if (a_as && a_iack && a_in) begin
          if (!(m_pend && m_d2[7:5] == MY_LVL)) nst = 1;
          else if (a_ds) begin nst = 2; m_cnt = 0; end
        end
      end else if (m_st == 1) begin
        if (!a_in) nst = 0;
      end else if (m_st == 2) begin
        if (!a_as) nst = 0;
        else if (m_cnt == DLY - 1) nst = 3;
        else m_cnt++;
      end else begin
        if (!a_as && !a_ds) nst = 0;
      end
      if (m_st == 3) m_pend = 0;
      else if (m_st == 0 && local_req) m_pend = 1;
      m_st = nst;
      m_d2 = m_d1;
      m_d1 = {addr_lvl, iackin_n, iack_n, ds1_n, ds0_n, as_n};
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      logic [3:0] exp_v, act_v;
      exp_v = {!m_pend, m_st != 1, !(m_st == 2 || m_st == 3), m_st != 3};
      act_v = {irq_n, iackout_n, vec_en_n, dtack_n};
      tests++;
      if (act_v !== exp_v) begin
        fails++;
        $display("FAIL %s model compare {irq,iackout,vec,dtack} act=%b exp=%b", tag, act_v, exp_v);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus(input logic a, input logic d0, input logic d1, input logic ik,
                     input logic ki, input logic [2:0] l);
    as_n = a; ds0_n = d0; ds1_n = d1; iack_n = ik; iackin_n = ki; addr_lvl = l;
  endtask

  task automatic raise_req();
    local_req = 1'b1; cyc(1); local_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    cyc(3);
    tag = "R1";
    chk("R1 irq_n", irq_n, 1'b1); chk("R1 iackout_n", iackout_n, 1'b1);
    chk("R1 vec_en_n", vec_en_n, 1'b1); chk("R1 dtack_n", dtack_n, 1'b1);
    rst = 1'b0;
    cyc(1);
    chk("R1 after release dtack_n", dtack_n, 1'b1);

    tag = "R2";
    raise_req();
    chk("R2 irq_n low", irq_n, 1'b0);
    cyc(4);
    chk("R2 irq_n held", irq_n, 1'b0);

    tag = "R3";
    bus(0, 0, 0, 1, 0, MY_LVL);
    cyc(6);
    chk("R3 vec_en_n", vec_en_n, 1'b1); chk("R3 iackout_n", iackout_n, 1'b1);
    bus(1, 1, 1, 1, 1, 3'd0);
    cyc(4);

    tag = "R4";
    bus(0, 0, 1, 0, 0, MY_LVL);
    cyc(2); chk("R4 vec_en_n before", vec_en_n, 1'b1);
    cyc(1); chk("R4 vec_en_n low", vec_en_n, 1'b0);
    tag = "R5";
    cyc(DLY - 1); chk("R5 dtack_n before", dtack_n, 1'b1);
    cyc(1); chk("R5 dtack_n low", dtack_n, 1'b0);
    tag = "R6";
    chk("R6 irq_n still low", irq_n, 1'b0);
    cyc(1); chk("R6 irq_n released", irq_n, 1'b1);
    tag = "R11";
    bus(1, 1, 1, 1, 1, 3'd0);
    cyc(2); chk("R11 dtack_n held", dtack_n, 1'b0);
    cyc(1); chk("R11 dtack_n released", dtack_n, 1'b1);
    chk("R11 vec_en_n released", vec_en_n, 1'b1);
    cyc(2);

    tag = "R7";
    raise_req(); cyc(1);
    bus(0, 0, 0, 0, 0, 3'd2);
    cyc(4);
    chk("R7 iackout_n low", iackout_n, 1'b0);
    chk("R7 vec_en_n high", vec_en_n, 1'b1);
    tag = "R9";
    iackin_n = 1'b1;
    cyc(2); chk("R9 iackout_n held", iackout_n, 1'b0);
    cyc(1); chk("R9 iackout_n released", iackout_n, 1'b1);
    bus(1, 1, 1, 1, 1, 3'd0);
    cyc(4);

    tag = "R10";
    bus(0, 1, 0, 0, 0, MY_LVL);
    cyc(3); chk("R10 ds1 only vec_en_n", vec_en_n, 1'b0);
    cyc(DLY); chk("R10 ds1 only dtack_n", dtack_n, 1'b0);
    bus(1, 1, 1, 1, 1, 3'd0);
    cyc(5);

    tag = "R8";
    bus(0, 0, 0, 0, 0, MY_LVL);
    cyc(4);
    chk("R8 iackout_n low", iackout_n, 1'b0);
    chk("R8 dtack_n high", dtack_n, 1'b1);
    bus(1, 1, 1, 1, 1, 3'd0);
    cyc(5);

    tag = "R10";
    raise_req(); cyc(1);
    bus(0, 0, 0, 0, 0, MY_LVL);
    cyc(3 + DLY); chk("R10 both strobes dtack_n", dtack_n, 1'b0);
    bus(1, 1, 1, 1, 1, 3'd0);
    cyc(5);

    tag = "R12";
    raise_req(); cyc(1);
    bus(0, 0, 0, 0, 1, MY_LVL);
    cyc(6);
    chk("R12 vec_en_n", vec_en_n, 1'b1);
    chk("R12 iackout_n", iackout_n, 1'b1);
    chk("R12 irq_n still pending", irq_n, 1'b0);
    bus(1, 1, 1, 1, 1, 3'd0);
    cyc(4);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end
endmodule